// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port that moves 8-bit frames with no start, stop or parity bits. Frames travel over a data-out line and a data-in line, timed by a shared transfer clock. The transfer clock comes from one of two places. The first is an internal baud divider, which then drives the clock pin. The second is an external master that drives the same pin, which is then only received. Software writes a byte into a transmit holding register. Whenever the port is enabled and that register holds data, the byte moves into a shift register and a frame runs. The transmitter is what produces the shift clock, so reception always rides on a transmission. A completed received byte lands in a receive holding register, and a one-cycle pulse tells the CPU side.

The options are set per frame and are expected to stay steady while a frame runs:
- clock polarity
- bit order
- when the transmit pulse fires (on taking the buffer, or after the last bit)
- a continuous-receive option, in which each read of the received byte starts the next frame by itself

If a new frame reaches its seventh sampled bit while the previous byte is still unread, the port flags an overrun. That frame then leaves the receive side untouched.

Top module: `sync_serial_port`

## Requirements
- R1: A frame is exactly 8 data bits carried by 16 transfer-clock transitions. While no frame runs, the clock pin rests high for `clk_pol`=0 and low for `clk_pol`=1. `sclk_oe` is 1 when `ext_clk`=0 (internal clock, pin driven) and 0 when `ext_clk`=1.
- R2: With `ext_clk`=0, each half period of the transfer clock lasts P*(n+1) system clock cycles. Here n is `div_n` (0 to 255), and P is 1, 8 or 32 for `presc_sel` = 0, 1, or 2/3.
- R3: With `clk_pol`=0, `sdo` changes on falling transfer-clock edges and `sdi` is sampled on rising edges. With `clk_pol`=1 the two edges swap. The first transition of a frame is always a data-change edge.
- R4: `msb_first`=0 moves bit 0 first and `msb_first`=1 moves bit 7 first, in both directions.
- R5: A frame starts only when `tx_en`=1 and `tx_empty`=0. Starting moves the buffer into the shift register and sets `tx_empty`. A `tx_wr` loads `tx_wdata` and clears `tx_empty`. After reset `tx_empty`=1.
- R6: A frame receives only if `rx_en` was 1 when it started. A frame run with `rx_en`=0 changes neither `rx_full`, `rx_data` nor `rx_irq`. With `tx_en`=0 no transfer clock runs, even with `rx_en`=1.
- R7: With `tx_irq_sel`=0, `tx_irq` pulses for one cycle as the frame starts, before its first clock transition. With `tx_irq_sel`=1 it pulses once, after the 16th transition.
- R8: At the end of a receiving frame, `rx_data` takes the received byte, `rx_full` is set and `rx_irq` pulses for one cycle. `rx_rd` clears `rx_full`. After reset `rx_full`=0.
- R9: `overrun` sets if `rx_full` is still 1, with no `rx_rd` in that cycle, when a receiving frame samples its 7th bit. Such a frame updates neither `rx_full` nor `rx_irq`. A read before the 7th sample prevents the overrun. `rx_en`=0 clears `overrun`. After reset `overrun`=0.
- R10: With `cont_rx`=1 and `rx_en`=1, an `rx_rd` starts a new frame without a `tx_wr`, resending the byte held in the transmit buffer. With `cont_rx`=0 a read starts nothing.
- R11: With `ext_clk`=1, transitions on `sclk_i` pass through a two-stage synchronizer and then drive the frame. R3 and R4 apply unchanged, and a frame waits for as long as the external clock takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ext_clk | input | 1 | 1 selects the external transfer clock on `sclk_i` |
| clk_pol | input | 1 | Transfer clock polarity |
| msb_first | input | 1 | Bit order select |
| tx_irq_sel | input | 1 | 0: pulse at frame start, 1: pulse at frame end |
| cont_rx | input | 1 | Continuous-receive enable |
| presc_sel | input | 2 | Prescaler select for the internal clock |
| div_n | input | DIV_W | Baud divider setting n |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable; 0 also clears `overrun` |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_wdata | input | DW | Byte written to the transmit buffer |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | DW | Receive buffer contents |
| tx_empty | output | 1 | Transmit buffer holds no data |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| overrun | output | 1 | Overrun error flag |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| sclk_o | output | 1 | Transfer clock driven in internal mode |
| sclk_oe | output | 1 | Output enable for the clock pin |
| sclk_i | input | 1 | Transfer clock received from the pin |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench acts as the far-end device across every polarity, bit order and prescaler setting, over several divider values including 255. It times each half period and checks which edge moved `sdo` and which edge sampled `sdi`. A swapped edge would corrupt the exchanged bytes, and an off-by-one divider would show as a wrong interval. The overrun boundary is probed by reading just after the sixth sample and just after the seventh: a design that tested a different bit would flag the first case or miss the second. Further checks cover the continuous-receive restart, a frame run with receive disabled, transmit gating, both interrupt timings and the external-clock path.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Prescaler ratio applied ahead of the baud divider.
  function automatic int unsigned presc_factor(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 8;
      default: return 32;
    endcase
  endfunction

  // System clock cycles per half period of the internal transfer clock.
  function automatic int unsigned half_period(input logic [1:0] sel, input int unsigned n);
    return presc_factor(sel) * (n + 1);
  endfunction

endpackage

// File: rtl/ssp_baud.sv
module ssp_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       presc_sel,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 6;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb limit = CNT_W'(ssp_pkg::half_period(presc_sel, 32'(div_n)) - 1);

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R2: a stopped divider restarts from zero, so the first half period is full length
  a_r2_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
  // R2: the count never runs past the programmed half period
  a_r2_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    run && $stable(presc_sel) && $stable(div_n) |-> cnt <= limit);

endmodule

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], pin};
  end

  assign rise =  sh[1] & ~sh[2];
  assign fall = ~sh[1] &  sh[2];

endmodule

// File: rtl/ssp_engine.sv
module ssp_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] load_word,
  input  logic          msb_first,
  input  logic          ev,
  input  logic          sdi,
  output logic          busy,
  output logic          done,
  output logic          sdo,
  output logic          want_lead,
  output logic          seventh,
  output logic [DW-1:0] rx_word
);
  localparam int EDGES    = 2 * DW;
  localparam int CW       = $clog2(EDGES);
  localparam int LAST     = EDGES - 1;
  localparam int OVR_EDGE = 2 * (DW - 2) + 1;

  logic [CW-1:0] cnt;
  logic [DW-1:0] txsr;
  logic [DW-1:0] rxsr;
  logic          step;

  assign step      = busy && ev;
  assign want_lead = ~cnt[0];
  assign seventh   = step && (cnt == CW'(OVR_EDGE));
  assign rx_word   = rxsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      txsr <= '0;
      rxsr <= '0;
      sdo  <= 1'b1;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        cnt  <= '0;
        txsr <= load_word;
      end else if (step) begin
        cnt <= cnt + 1'b1;
        if (!cnt[0]) begin
          sdo  <= msb_first ? txsr[DW-1] : txsr[0];
          txsr <= msb_first ? {txsr[DW-2:0], 1'b0} : {1'b0, txsr[DW-1:1]};
        end else begin
          rxsr <= msb_first ? {rxsr[DW-2:0], sdi} : {sdi, rxsr[DW-1:1]};
        end
        if (cnt == CW'(LAST)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R3: data out holds still across a sampling edge
  a_r3_sdo_hold_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    step && cnt[0] |=> $stable(sdo));
  // R1: a frame ends only out of a running frame
  a_r1_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DW    = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             clk_pol,
  input  logic             msb_first,
  input  logic             tx_irq_sel,
  input  logic             cont_rx,
  input  logic [1:0]       presc_sel,
  input  logic [DIV_W-1:0] div_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             tx_wr,
  input  logic [DW-1:0]    tx_wdata,
  input  logic             rx_rd,
  output logic [DW-1:0]    rx_data,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             overrun,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             sclk_o,
  output logic             sclk_oe,
  input  logic             sclk_i,
  output logic             sdo,
  input  logic             sdi
);
  logic          tick, x_rise, x_fall, ext_ev, ev, start;
  logic          busy, done, want_lead, seventh;
  logic [DW-1:0] rx_word, tx_buf, rx_buf;
  logic          rearm, rx_act, frame_ovr, sclk_lvl;

  ssp_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .run(busy && !ext_clk),
    .presc_sel(presc_sel), .div_n(div_n), .tick(tick)
  );

  ssp_edge_sync sync_i (
    .clk(clk), .rst_n(rst_n), .pin(sclk_i), .rise(x_rise), .fall(x_fall)
  );

  // Leading (data-change) edge is falling for polarity 0, rising for polarity 1.
  assign ext_ev = want_lead ? (clk_pol ? x_rise : x_fall)
                            : (clk_pol ? x_fall : x_rise);
  assign ev     = ext_clk ? ext_ev : tick;
  assign start  = tx_en && !busy && (!tx_empty || rearm);

  ssp_engine #(.DW(DW)) eng_i (
    .clk(clk), .rst_n(rst_n), .start(start), .load_word(tx_buf),
    .msb_first(msb_first), .ev(ev), .sdi(sdi), .busy(busy), .done(done),
    .sdo(sdo), .want_lead(want_lead), .seventh(seventh), .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf    <= '0;
      tx_empty  <= 1'b1;
      rearm     <= 1'b0;
      rx_act    <= 1'b0;
      frame_ovr <= 1'b0;
      rx_buf    <= '0;
      rx_full   <= 1'b0;
      overrun   <= 1'b0;
      tx_irq    <= 1'b0;
      rx_irq    <= 1'b0;
      sclk_lvl  <= 1'b1;
    end else begin
      tx_irq <= 1'b0;
      rx_irq <= 1'b0;

      if (tx_wr) begin
        tx_buf   <= tx_wdata;
        tx_empty <= 1'b0;
      end else if (start) begin
        tx_empty <= 1'b1;
      end

      if (start) begin
        rearm     <= 1'b0;
        rx_act    <= rx_en;
        frame_ovr <= 1'b0;
        if (!tx_irq_sel) tx_irq <= 1'b1;
      end else if (cont_rx && rx_en && rx_rd) begin
        rearm <= 1'b1;
      end

      if (seventh && rx_act && rx_full && !rx_rd) begin
        overrun   <= 1'b1;
        frame_ovr <= 1'b1;
      end
      if (!rx_en) overrun <= 1'b0;

      if (done && tx_irq_sel) tx_irq <= 1'b1;
      if (done && rx_act && !frame_ovr) begin
        rx_buf  <= rx_word;
        rx_irq  <= 1'b1;
        rx_full <= 1'b1;
      end else if (rx_rd) begin
        rx_full <= 1'b0;
      end

      if (!busy)                 sclk_lvl <= ~clk_pol;
      else if (ev && !ext_clk)   sclk_lvl <= ~sclk_lvl;
    end
  end

  assign rx_data = rx_buf;
  assign sclk_o  = sclk_lvl;
  assign sclk_oe = ~ext_clk;

  // R5: a frame begins only with transmit enabled
  a_r5_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_en));
  // R7: early transmit pulse coincides with the frame start
  a_r7_early_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && $past(!tx_irq_sel) |-> tx_irq);
  // R8: a receive pulse always leaves an unread byte behind
  a_r8_irq_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);
  // R9: overrun only arises over an unread byte
  a_r9_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> rx_full);
  // R1: the clock rests at its idle level between frames
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) && $stable(clk_pol) |-> sclk_o == ~clk_pol);

endmodule

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk = 1'b0, clk_pol = 1'b0, msb_first = 1'b0, tx_irq_sel = 1'b0, cont_rx = 1'b0;
  logic [1:0] presc_sel = '0;
  logic [7:0] div_n = '0;
  logic tx_en = 1'b0, rx_en = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_wdata = '0;
  logic [7:0] rx_data;
  logic tx_empty, rx_full, overrun, tx_irq, rx_irq, sclk_o, sclk_oe, sdo;
  logic sclk_i = 1'b1, sdi = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;
  int edges, bad_hp, bad_dir, txirqs, txirq_edge, rxirqs;
  logic [7:0] cap;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .clk_pol(clk_pol), .msb_first(msb_first),
    .tx_irq_sel(tx_irq_sel), .cont_rx(cont_rx), .presc_sel(presc_sel), .div_n(div_n),
    .tx_en(tx_en), .rx_en(rx_en), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
    .rx_data(rx_data), .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i),
    .sdo(sdo), .sdi(sdi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bidx(input int i);
    return msb_first ? 7 - i : i;
  endfunction

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_rx();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic quiet(input int n, output int chg);
    logic last;
    last = sclk_o;
    chg = 0;
    repeat (n) begin
      @(negedge clk);
      if (sclk_o !== last) begin chg++; last = sclk_o; end
    end
  endtask

  // Far-end device for an internally clocked frame.
  task automatic run_int(input logic [7:0] sb, input bit wr, input logic [7:0] txb,
                         input bit rd_first, input int rd_edge, input int hp);
    int since, cyc;
    logic last;
    edges = 0; bad_hp = 0; bad_dir = 0; txirqs = 0; txirq_edge = -1; rxirqs = 0; cap = '0;
    if (wr) begin
      tx_wdata = txb; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
    end else if (rd_first) begin
      rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    end
    last = sclk_o; since = 0; cyc = 0;
    while (edges < 16 && cyc < 20000) begin
      @(negedge clk);
      cyc++; since++; rx_rd = 1'b0;
      if (tx_irq) begin txirqs++; txirq_edge = edges; end
      if (rx_irq) rxirqs++;
      if (sclk_o !== last) begin
        edges++; last = sclk_o;
        if (edges > 1 && since != hp) bad_hp++;
        since = 0;
        if (edges % 2 == 1) begin
          if (sclk_o !== clk_pol) bad_dir++;
          sdi = sb[bidx((edges - 1) / 2)];
        end else begin
          if (sclk_o !== ~clk_pol) bad_dir++;
          cap[bidx((edges - 2) / 2)] = sdo;
        end
        if (edges == rd_edge) rx_rd = 1'b1;
      end
    end
    repeat (4) begin
      @(negedge clk);
      rx_rd = 1'b0;
      if (tx_irq) begin txirqs++; txirq_edge = edges; end
      if (rx_irq) rxirqs++;
    end
  endtask

  // Far-end device acting as clock master.
  task automatic run_ext(input logic [7:0] txb, input logic [7:0] sb);
    rxirqs = 0; cap = '0;
    tx_wdata = txb; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
    tick_n(4);
    for (int e = 0; e < 16; e++) begin
      if (e % 2 == 1) cap[bidx(e / 2)] = sdo;
      sclk_i = ~sclk_i;
      if (e % 2 == 0) sdi = sb[bidx(e / 2)];
      repeat (8) begin @(negedge clk); if (rx_irq) rxirqs++; end
    end
    repeat (4) begin @(negedge clk); if (rx_irq) rxirqs++; end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k, hp, chg;
    logic [7:0] txb, sb;
    tick_n(3);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk(tx_empty === 1'b1, "R5 reset tx_empty", int'(tx_empty), 1);
    chk(rx_full === 1'b0, "R8 reset rx_full", int'(rx_full), 0);
    chk(overrun === 1'b0, "R9 reset overrun", int'(overrun), 0);
    chk(sclk_o === 1'b1, "R1 reset idle level", int'(sclk_o), 1);
    chk(sclk_oe === 1'b1, "R1 internal drives pin", int'(sclk_oe), 1);

    // Sweep of polarity, order, prescaler and divider
    tx_en = 1'b1; rx_en = 1'b1;
    k = 0;
    for (int pol = 0; pol < 2; pol++)
      for (int mf = 0; mf < 2; mf++)
        for (int ps = 0; ps < 4; ps++)
          for (int nn = 0; nn < 2; nn++) begin
            clk_pol = 1'(pol); msb_first = 1'(mf); presc_sel = 2'(ps);
            div_n = 8'(nn * 2); tx_irq_sel = 1'(k % 2);
            tick_n(2);
            hp = (ps == 0 ? 1 : (ps == 1 ? 8 : 32)) * (nn * 2 + 1);
            txb = 8'(37 * k + 5); sb = 8'(91 * k + 108);
            run_int(sb, 1'b1, txb, 1'b0, -1, hp);
            chk(edges == 16, "R1 transitions per frame", edges, 16);
            chk(bad_hp == 0, "R2 half period length", bad_hp, 0);
            chk(bad_dir == 0, "R3 edge roles", bad_dir, 0);
            chk(cap == txb, "R4 transmitted byte", int'(cap), int'(txb));
            chk(rx_data == sb, "R4 received byte", int'(rx_data), int'(sb));
            chk(rx_full === 1'b1 && rxirqs == 1, "R8 receive flag and pulse", rxirqs, 1);
            chk(txirqs == 1 && txirq_edge == (tx_irq_sel ? 16 : 0), "R7 transmit pulse timing",
                txirq_edge, tx_irq_sel ? 16 : 0);
            chk(tx_empty === 1'b1, "R5 buffer emptied by start", int'(tx_empty), 1);
            chk(sclk_o === ~clk_pol, "R1 idle level after frame", int'(sclk_o), int'(~clk_pol));
            read_rx();
            chk(rx_full === 1'b0, "R8 read clears full", int'(rx_full), 0);
            k++;
          end

    // Largest divider setting
    clk_pol = 1'b0; msb_first = 1'b0; presc_sel = 2'd0; div_n = 8'd255; tx_irq_sel = 1'b0;
    tick_n(2);
    run_int(8'h6B, 1'b1, 8'hD2, 1'b0, -1, 256);
    chk(bad_hp == 0 && edges == 16, "R2 divider 255", bad_hp, 0);
    chk(rx_data == 8'h6B, "R2 byte at divider 255", int'(rx_data), 'h6B);
    read_rx();

    div_n = 8'd1;
    tick_n(2);

    // Transmit gating
    tx_en = 1'b0;
    tx_wdata = 8'h81; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
    quiet(300, chg);
    chk(chg == 0, "R6 no clock without transmit enable", chg, 0);
    chk(tx_empty === 1'b0, "R5 buffer held while disabled", int'(tx_empty), 0);
    tx_en = 1'b1;
    run_int(8'h42, 1'b0, 8'h00, 1'b0, -1, 2);
    chk(edges == 16 && cap == 8'h81, "R5 start on enable", int'(cap), 'h81);
    chk(rx_data == 8'h42, "R5 byte after enable", int'(rx_data), 'h42);
    read_rx();
    quiet(200, chg);
    chk(chg == 0, "R5 no frame with empty buffer", chg, 0);

    // Receive disabled
    rx_en = 1'b0;
    run_int(8'h77, 1'b1, 8'h11, 1'b0, -1, 2);
    chk(edges == 16, "R6 transmit still runs", edges, 16);
    chk(rx_full === 1'b0 && rxirqs == 0, "R6 receive side untouched", rxirqs, 0);
    chk(rx_data == 8'h42, "R6 buffer unchanged", int'(rx_data), 'h42);
    rx_en = 1'b1;

    // Overrun boundary
    run_int(8'h3C, 1'b1, 8'h01, 1'b0, -1, 2);
    chk(rx_full === 1'b1 && rx_data == 8'h3C, "R8 first byte", int'(rx_data), 'h3C);
    run_int(8'hA5, 1'b1, 8'h02, 1'b0, 12, 2);
    chk(overrun === 1'b0, "R9 read before 7th sample", int'(overrun), 0);
    chk(rx_data == 8'hA5 && rxirqs == 1, "R9 byte after timely read", int'(rx_data), 'hA5);
    run_int(8'h5A, 1'b1, 8'h03, 1'b0, -1, 2);
    chk(overrun === 1'b1, "R9 overrun on unread byte", int'(overrun), 1);
    chk(rxirqs == 0 && rx_full === 1'b1, "R9 no receive pulse on overrun", rxirqs, 0);
    rx_en = 1'b0; tick_n(2);
    chk(overrun === 1'b0, "R9 cleared by receive disable", int'(overrun), 0);
    rx_en = 1'b1; tick_n(1);
    run_int(8'h33, 1'b1, 8'h04, 1'b0, 14, 2);
    chk(overrun === 1'b1, "R9 read after 7th sample too late", int'(overrun), 1);
    chk(rxirqs == 0 && rx_full === 1'b0, "R9 late frame not stored", int'(rx_full), 0);
    rx_en = 1'b0; tick_n(2); rx_en = 1'b1; tick_n(1);

    // Continuous receive
    cont_rx = 1'b1;
    run_int(8'hC3, 1'b1, 8'h5E, 1'b0, -1, 2);
    chk(rx_data == 8'hC3, "R10 first byte", int'(rx_data), 'hC3);
    run_int(8'h96, 1'b0, 8'h00, 1'b1, -1, 2);
    chk(edges == 16 && cap == 8'h5E, "R10 read restarts and resends", int'(cap), 'h5E);
    chk(rx_data == 8'h96 && rx_full === 1'b1, "R10 restarted byte", int'(rx_data), 'h96);
    cont_rx = 1'b0;
    read_rx();
    quiet(200, chg);
    chk(chg == 0 && rx_full === 1'b0, "R10 read without continuous mode", chg, 0);

    // External clock
    ext_clk = 1'b1;
    for (int pol = 0; pol < 2; pol++)
      for (int mf = 0; mf < 2; mf++) begin
        clk_pol = 1'(pol); msb_first = 1'(mf); sclk_i = ~clk_pol;
        tick_n(6);
        txb = 8'(8'h2D + 8'(pol * 64 + mf * 17)); sb = 8'(8'hE4 - 8'(pol * 33 + mf * 5));
        run_ext(txb, sb);
        chk(sclk_oe === 1'b0, "R1 pin released for external clock", int'(sclk_oe), 0);
        chk(cap == txb, "R11 transmitted byte", int'(cap), int'(txb));
        chk(rx_data == sb && rxirqs == 1, "R11 received byte", int'(rx_data), int'(sb));
        read_rx();
      end
    ext_clk = 1'b0;
    tick_n(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule